// File: doc/BRIEF.md
# Write Data Pattern Sequencer

This block drives one write transaction onto a shared address/data bus. When it accepts a request it places the address on the bus for one cycle. It then leaves a programmable number of quiet cycles. After that it sends the data beats, spaced by a pattern code that sets how many beats go out in each group and how many idle cycles follow each group. Each data word comes from an upstream source. The source always shows its head word, and the sequencer takes that word with a pop strobe.

The bus can run full width or half width. The width decides how many beats a transfer needs. A cache-line block write takes four full-width beats or eight half-width beats. A single write takes one beat, unless it is larger than a half-width word on the narrow bus, in which case it takes two. A one-cycle completion pulse marks the last beat. Pattern codes outside the defined set fall back to back-to-back beats and raise a flag.

Top module: `wr_beat_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_valid`, `done`, `pat_err` and `src_pop` are low and `bus_ad` is zero.
- R2: In the cycle after an idle edge that samples `req_valid` high, `bus_ad` carries `req_addr` and `bus_valid` is high. In narrow mode the upper half of the bus is zero.
- R3: Exactly `req_gap` cycles (0 to 7) with `bus_valid` low separate the address cycle from the first pattern slot. A gap of 0 puts the first beat in the cycle right after the address.
- R4: Counted from the first slot after the gap, `req_pat` selects beats per group and period as follows: 0 gives 1 of 1, 1 gives 2 of 3, 2 gives 2 of 4, 3 gives 1 of 2, 4 gives 2 of 5, 5 gives 2 of 6, 6 gives 1 of 3, 7 gives 2 of 8, and 8 gives 1 of 4. Beats occupy the first slots of each period.
- R5: A block write (`req_block`=1) sends 4 beats when `req_narrow`=0 and 8 beats when `req_narrow`=1. A single write sends 1 beat, or 2 beats when both `req_narrow` and `req_big` are 1.
- R6: In every cycle with `bus_valid` low, `bus_ad` keeps its value from the previous cycle.
- R7: `src_pop` is high in exactly the cycle before each data beat. That beat carries the `src_data` presented while `src_pop` was high, with the upper half zeroed in narrow mode.
- R8: `done` is a one-cycle pulse that coincides with the final data beat of a transfer.
- R9: A `req_pat` value of 9 to 15 is sent as pattern 0 and sets `pat_err`. The flag holds until the next accepted request, which loads it again from that request's code.
- R10: A request raised while a transfer is in progress is ignored. A request raised in the cycle that `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (sampled while idle) |
| req_block | input | 1 | 1 = cache-line block write, 0 = single write |
| req_big | input | 1 | Single write wider than a half-width word |
| req_narrow | input | 1 | 1 = half-width bus mode |
| req_addr | input | DW | Write address |
| req_pat | input | PCW | Beat spacing pattern code |
| req_gap | input | GW | Address-to-data idle cycles |
| src_data | input | DW | Head word of the data source |
| src_pop | output | 1 | Consume head word at this clock edge |
| bus_ad | output | DW | Multiplexed address/data bus |
| bus_valid | output | 1 | Bus carries an address or data beat |
| done | output | 1 | Final data beat of the transfer |
| pat_err | output | 1 | Last accepted pattern code was reserved |

## Verification
Two events can land on the same cycle. One is the completion pulse on the final beat. The other is a new request that the idle controller samples at the end of that cycle. The bench raises a request exactly in the `done` cycle, so the next address must appear one cycle after the last beat with no gap. It also raises a conflicting request in the middle of a transfer, including on slots where a beat is being popped. A reference model predicts the bus, strobe, pop and flag cycle by cycle, and the bench compares against it on every clock. Any cycle where the sequencer mixes up the end of one transfer with the start of the next shows up as a mismatch.

// File: rtl/wr_beat_seq.sv
module wr_beat_seq #(
  parameter int DW         = 64,
  parameter int LINE_BYTES = 32,
  parameter int PCW        = 4,
  parameter int GW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_block,
  input  logic          req_big,
  input  logic          req_narrow,
  input  logic [DW-1:0] req_addr,
  input  logic [PCW-1:0] req_pat,
  input  logic [GW-1:0] req_gap,
  input  logic [DW-1:0] src_data,
  output logic          src_pop,
  output logic [DW-1:0] bus_ad,
  output logic          bus_valid,
  output logic          done,
  output logic          pat_err
);
  localparam int HW           = DW / 2;
  localparam int WIDE_BEATS   = LINE_BYTES / (DW / 8);
  localparam int NARROW_BEATS = 2 * WIDE_BEATS;
  localparam int CW           = $clog2(NARROW_BEATS + 1);
  localparam int SW           = 3;
  localparam int LAST_CODE    = 8;

  logic          busy, narrow_q;
  logic [GW-1:0] gap_left;
  logic [SW-1:0] slot, per_last, per_dec;
  logic [1:0]    grp, grp_dec;
  logic [CW-1:0] beats_left, beats_req;
  logic          in_gap, beat_slot;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic nar);
    return nar ? {{(DW-HW){1'b0}}, d[HW-1:0]} : d;
  endfunction

  always_comb begin
    case (req_pat)
      4'd1:    begin grp_dec = 2'd2; per_dec = 3'd2; end
      4'd2:    begin grp_dec = 2'd2; per_dec = 3'd3; end
      4'd3:    begin grp_dec = 2'd1; per_dec = 3'd1; end
      4'd4:    begin grp_dec = 2'd2; per_dec = 3'd4; end
      4'd5:    begin grp_dec = 2'd2; per_dec = 3'd5; end
      4'd6:    begin grp_dec = 2'd1; per_dec = 3'd2; end
      4'd7:    begin grp_dec = 2'd2; per_dec = 3'd7; end
      4'd8:    begin grp_dec = 2'd1; per_dec = 3'd3; end
      default: begin grp_dec = 2'd1; per_dec = 3'd0; end
    endcase
  end

  assign beats_req = req_block ? (req_narrow ? CW'(NARROW_BEATS) : CW'(WIDE_BEATS))
                               : ((req_narrow && req_big) ? CW'(2) : CW'(1));

  assign in_gap    = busy && (gap_left != '0);
  assign beat_slot = busy && !in_gap && (slot < SW'(grp));
  assign src_pop   = beat_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      narrow_q   <= 1'b0;
      gap_left   <= '0;
      slot       <= '0;
      per_last   <= '0;
      grp        <= '0;
      beats_left <= '0;
      bus_ad     <= '0;
      bus_valid  <= 1'b0;
      done       <= 1'b0;
      pat_err    <= 1'b0;
    end else begin
      bus_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy       <= 1'b1;
          bus_valid  <= 1'b1;
          bus_ad     <= fit(req_addr, req_narrow);
          narrow_q   <= req_narrow;
          gap_left   <= req_gap;
          slot       <= '0;
          grp        <= grp_dec;
          per_last   <= per_dec;
          beats_left <= beats_req;
          pat_err    <= (req_pat > PCW'(LAST_CODE));
        end
      end else if (in_gap) begin
        gap_left <= gap_left - 1'b1;
      end else begin
        slot <= (slot == per_last) ? '0 : slot + 1'b1;
        if (beat_slot) begin
          bus_valid  <= 1'b1;
          bus_ad     <= fit(src_data, narrow_q);
          beats_left <= beats_left - 1'b1;
          if (beats_left == CW'(1)) begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wr_beat_seq_chk.sv
module wr_beat_seq_chk #(
  parameter int DW  = 64,
  parameter int PCW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [PCW-1:0] req_pat,
  input logic           src_pop,
  input logic [DW-1:0]  bus_ad,
  input logic           bus_valid,
  input logic           done,
  input logic           pat_err
);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> bus_ad == $past(bus_ad));

  // R7
  pop_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> bus_valid);

  // R8
  done_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bus_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pat_err) |-> ($past(req_valid) && ($past(req_pat) > PCW'(8))));

  // R9
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pat_err) |-> $past(req_valid));
endmodule

bind wr_beat_seq wr_beat_seq_chk #(.DW(DW), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pat(req_pat),
  .src_pop(src_pop), .bus_ad(bus_ad), .bus_valid(bus_valid), .done(done),
  .pat_err(pat_err)
);

// File: tb/tb_wr_beat_seq.sv
module tb_wr_beat_seq;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_block = 1'b0, req_big = 1'b0, req_narrow = 1'b0;
  logic [DW-1:0] req_addr = '0;
  logic [3:0]    req_pat = '0;
  logic [2:0]    req_gap = '0;
  logic [DW-1:0] src_data;
  logic          src_pop, bus_valid, done, pat_err;
  logic [DW-1:0] bus_ad;

  always #10 clk = ~clk;

  wr_beat_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .req_big(req_big), .req_narrow(req_narrow), .req_addr(req_addr),
    .req_pat(req_pat), .req_gap(req_gap), .src_data(src_data),
    .src_pop(src_pop), .bus_ad(bus_ad), .bus_valid(bus_valid),
    .done(done), .pat_err(pat_err)
  );

  typedef struct packed {
    logic          v;
    logic          beat;
    logic          fin;
    logic [DW-1:0] d;
  } cyc_t;

  cyc_t          q[$];
  int            checks = 0, fails = 0;
  int            src_idx = 0, mdl_idx = 0;
  logic [DW-1:0] last_bus = '0;
  logic          exp_err = 1'b0;
  bit            mon_on = 1'b0;
  string         tag = "R1";

  function automatic logic [DW-1:0] word_of(int i);
    logic [31:0] a, b;
    a = 32'h9E3779B1 * (i + 1);
    b = 32'h7F4A7C15 ^ (i * 32'h01000193);
    return {a, b};
  endfunction

  function automatic logic [DW-1:0] fitw(logic [DW-1:0] d, logic nar);
    return nar ? {32'h0, d[31:0]} : d;
  endfunction

  assign src_data = word_of(src_idx);
  always @(posedge clk) if (rst_n && src_pop) src_idx <= src_idx + 1;

  task automatic chk(string r, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (mon_on) begin
      cyc_t e;
      logic ev, efin, epop;
      logic [DW-1:0] ed;
      if (q.size() > 0) begin
        e = q.pop_front();
        ev = e.v; efin = e.fin;
        ed = e.v ? e.d : last_bus;
      end else begin
        ev = 1'b0; efin = 1'b0; ed = last_bus;
      end
      if (ev) last_bus = ed;
      epop = (q.size() > 0) && q[0].beat;
      chk(tag, "bus_valid", DW'(bus_valid), DW'(ev));
      chk(ev ? tag : "R6", "bus_ad", bus_ad, ed);
      chk("R8", "done", DW'(done), DW'(efin));
      chk("R7", "src_pop", DW'(src_pop), DW'(epop));
      chk("R9", "pat_err", DW'(pat_err), DW'(exp_err));
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic send(string r, bit blk, bit big, bit nar, int code, int gap, logic [DW-1:0] addr);
    int grp, per, n, slot;
    cyc_t e;
    wait_idle();
    tag = r;
    req_valid = 1'b1; req_block = blk; req_big = big; req_narrow = nar;
    req_pat = 4'(code); req_gap = 3'(gap); req_addr = addr;
    exp_err = (code > 8);
    case (code)
      1: begin grp = 2; per = 3; end
      2: begin grp = 2; per = 4; end
      3: begin grp = 1; per = 2; end
      4: begin grp = 2; per = 5; end
      5: begin grp = 2; per = 6; end
      6: begin grp = 1; per = 3; end
      7: begin grp = 2; per = 8; end
      8: begin grp = 1; per = 4; end
      default: begin grp = 1; per = 1; end
    endcase
    n = blk ? (nar ? 8 : 4) : ((nar && big) ? 2 : 1);
    e = '{v: 1'b1, beat: 1'b0, fin: 1'b0, d: fitw(addr, nar)};
    q.push_back(e);
    for (int g = 0; g < gap; g++) q.push_back('0);
    slot = 0;
    while (n > 0) begin
      if (slot < grp) begin
        e = '{v: 1'b1, beat: 1'b1, fin: (n == 1), d: fitw(word_of(mdl_idx), nar)};
        mdl_idx++;
        n--;
      end else e = '0;
      q.push_back(e);
      slot = (slot + 1) % per;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "bus_valid in reset", DW'(bus_valid), '0);
    chk("R1", "done in reset", DW'(done), '0);
    chk("R1", "bus_ad in reset", bus_ad, '0);
    chk("R1", "src_pop in reset", DW'(src_pop), '0);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    chk("R1", "bus_valid after reset", DW'(bus_valid), '0);
    chk("R1", "pat_err after reset", DW'(pat_err), '0);
    mon_on = 1'b1;

    send("R2", 1, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0);
    send("R2", 1, 0, 1, 0, 0, 64'hFFFF_0000_CAFE_0004);
    for (int g = 0; g < 8; g++) send("R3", 0, 0, 0, 0, g, 64'h100 + 64'(g));
    for (int c = 0; c < 9; c++) send("R4", 1, 0, 0, c, 2, 64'h2000 + 64'(c));
    for (int c = 0; c < 9; c++) send("R4", 1, 0, 1, c, 1, 64'h3000 + 64'(c));
    send("R5", 0, 0, 1, 3, 7, 64'h40);
    send("R5", 0, 1, 1, 1, 0, 64'h48);
    send("R5", 0, 1, 0, 7, 3, 64'h50);
    send("R5", 1, 1, 1, 8, 5, 64'h60);
    send("R9", 1, 0, 0, 12, 1, 64'h70);
    send("R9", 0, 0, 0, 15, 0, 64'h78);
    send("R9", 1, 0, 0, 5, 0, 64'h80);

    send("R10", 1, 0, 1, 2, 2, 64'h90);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_pat = 4'd11; req_gap = 3'd7; req_addr = 64'hDEAD;
      req_block = 1'b0; req_narrow = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) send("R10", 1, 0, 0, k, 0, 64'hA0 + 64'(k));
    send("R10", 0, 1, 1, 0, 0, 64'hB0);
    send("R10", 0, 0, 0, 0, 0, 64'hB8);

    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8", "queue drained", DW'(q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule